// File: doc/BRIEF.md
# Four-Level Transmit FIR Equalizer Without Multipliers

This block pre-distorts a stream of four-level line symbols before they reach a converter. Each 2-bit symbol stands for one of the levels -3, -1, +1 or +3. The symbols pass through a 16-tap FIR filter whose signed 10-bit weights are written through a small load port. No tap contains a multiplier. When a weight is written, the bank stores both the weight and three times the weight. At run time a 4:1 selector picks the tap product from those two stored values and their negations, using the symbol code.

The filter sums the products through a five-register pipeline. Two copies of this pipeline run side by side at half rate: one lane computes the even outputs and the other the odd outputs. Each lane turns its sum into a 4-bit level and expands that level into a 15-line thermometer code. A 2:1 selector driven by a phase bit interleaves the two lanes back into one output per clock, in the original symbol order.

A valid flag follows every symbol. An invalid slot contributes nothing to the sums and produces an all-zero output. The output for a symbol appears a fixed number of cycles after the symbol is presented.

Top module: `pam4_fir_eq`

## Requirements
- R1: Symbol codes map to levels as follows: 2'b00 is -3, 2'b01 is -1, 2'b11 is +1 and 2'b10 is +3.
- R2: A valid output carries level L = floor(S / 2^SHIFT) + 8 with SHIFT = 6, where S is the sum over taps of weight times symbol level. Thermometer line i (0 to 14) is high exactly when L > i.
- R3: L saturates at 0 (all lines low) and at 15 (all lines high). It never wraps.
- R4: The output for the symbol presented in cycle c appears in cycle c+11 for every symbol, whatever the lane phase. out_vld in cycle c+11 equals sym_vld in cycle c.
- R5: A slot presented with sym_vld low contributes zero to every output whose window covers it. Whenever out_vld is low, out_therm is all zeros.
- R6: The weight at index k multiplies the symbol presented k cycles before the current one. Index 0 is the current symbol.
- R7: After reset all weights are zero, so every valid output is at level 8.
- R8: A symbol is accepted in every cycle. Consecutive outputs alternate between the even and odd lanes with no reordering or loss.
- R9: Weights cover the full range -512 to +511. The stored triple has two bits of headroom, so the extreme products (including -3 times -512) do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Write strobe for one weight |
| coef_idx | input | 4 | Tap index of the write |
| coef_val | input | 10 | Signed weight value |
| sym_vld | input | 1 | Symbol slot holds a live symbol |
| sym | input | 2 | Gray-coded four-level symbol |
| out_vld | output | 1 | Output slot is live |
| out_therm | output | 15 | Thermometer-coded output level |

## Verification
Long runs with zero weights and a single unit weight at tap 0 separate the level mapping from the summation, because each symbol code must land on its own level. Moving the unit weight to tap 5 tests the ordering of the delay line. Random weights on a stream with random gaps exercise both lanes and the zero contribution of dead slots. Runs of all +3 and all -3 symbols against extreme positive and negative weights drive both clamps and the tripled-value headroom.

// File: rtl/pam4_eq_pkg.sv
package pam4_eq_pkg;

    // Gray coding of the four line levels
    typedef enum logic [1:0] {
        SYM_M3 = 2'b00,
        SYM_M1 = 2'b01,
        SYM_P1 = 2'b11,
        SYM_P3 = 2'b10
    } pam4_sym_e;

    // one delay-line slot: liveness plus symbol code
    typedef struct packed {
        logic       live;
        logic [1:0] sym;
    } tap_sym_t;

endpackage

// File: rtl/pam4_coef_bank.sv
module pam4_coef_bank #(
    parameter int NTAPS = 16,
    parameter int CW    = 10,
    localparam int IDXW = $clog2(NTAPS),
    localparam int PW   = CW + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [IDXW-1:0]           idx_i,
    input  logic [CW-1:0]             val_i,
    output logic [NTAPS-1:0][CW-1:0]  w_o,
    output logic [NTAPS-1:0][PW-1:0]  w3_o
);

    typedef struct packed {
        logic [NTAPS-1:0][CW-1:0] w;
        logic [NTAPS-1:0][PW-1:0] w3;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        logic signed [PW-1:0] ext;
        st_d = st_q;
        ext  = PW'($signed(val_i));
        if (we_i && (int'(idx_i) < NTAPS)) begin
            st_d.w[idx_i]  = val_i;
            st_d.w3[idx_i] = ext + (ext <<< 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign w_o  = st_q.w;
    assign w3_o = st_q.w3;

    // R6: a write lands in the addressed tap
    assert_coef_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> w_o[$past(idx_i)] == $past(val_i));

    // R9: the tripled copy keeps the sign and magnitude of the written weight
    assert_triple_headroom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> $signed(w3_o[$past(idx_i)]) == 3 * $signed($past(val_i)));

endmodule

// File: rtl/pam4_eq_lane.sv
module pam4_eq_lane
    import pam4_eq_pkg::*;
#(
    parameter int NTAPS = 16,
    parameter int CW    = 10,
    parameter int SHIFT = 6,
    parameter int LVLW  = 4,
    localparam int PW     = CW + 2,
    localparam int SUMW   = PW + $clog2(NTAPS),
    localparam int N2     = NTAPS / 2,
    localparam int N3     = NTAPS / 4,
    localparam int N4     = NTAPS / 8,
    localparam int NLINES = (1 << LVLW) - 1,
    localparam int MID    = 1 << (LVLW - 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  tap_sym_t [NTAPS-1:0]      win_i,
    input  logic [NTAPS-1:0][CW-1:0]  w_i,
    input  logic [NTAPS-1:0][PW-1:0]  w3_i,
    output logic                      vld_o,
    output logic [NLINES-1:0]         therm_o
);

    typedef struct packed {
        logic [NTAPS-1:0][PW-1:0] p1;   // stage 1: selected tap products
        logic [N2-1:0][SUMW-1:0]  p2;   // stage 2: first reduction
        logic [N3-1:0][SUMW-1:0]  p3;   // stage 3: second reduction
        logic [N4-1:0][SUMW-1:0]  p4;   // stage 4: third reduction
        logic [LVLW-1:0]          lvl;  // stage 5: clamped level
        logic [4:0]               v;    // valid per stage
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        logic signed [PW-1:0]   ew;
        logic signed [PW-1:0]   e3;
        logic signed [PW-1:0]   pk;
        logic signed [SUMW-1:0] acc;
        logic signed [SUMW-1:0] shv;
        logic signed [SUMW:0]   lv;
        st_d = st_q;
        ew   = '0;
        e3   = '0;
        pk   = '0;
        acc  = '0;
        shv  = '0;
        lv   = '0;
        if (en_i) begin
            for (int k = 0; k < NTAPS; k++) begin
                ew = PW'($signed(w_i[k]));
                e3 = $signed(w3_i[k]);
                case (pam4_sym_e'(win_i[k].sym))
                    SYM_M3:  pk = -e3;
                    SYM_M1:  pk = -ew;
                    SYM_P1:  pk = ew;
                    default: pk = e3;
                endcase
                if (!win_i[k].live) pk = '0;
                st_d.p1[k] = pk;
            end
            for (int j = 0; j < N2; j++)
                st_d.p2[j] = SUMW'($signed(st_q.p1[2*j])) + SUMW'($signed(st_q.p1[2*j+1]));
            for (int j = 0; j < N3; j++)
                st_d.p3[j] = $signed(st_q.p2[2*j]) + $signed(st_q.p2[2*j+1]);
            for (int j = 0; j < N4; j++)
                st_d.p4[j] = $signed(st_q.p3[2*j]) + $signed(st_q.p3[2*j+1]);
            for (int j = 0; j < N4; j++)
                acc = acc + $signed(st_q.p4[j]);
            shv = acc >>> SHIFT;
            lv  = (SUMW+1)'(shv) + (SUMW+1)'(MID);
            if (lv < 0)            st_d.lvl = '0;
            else if (lv > NLINES)  st_d.lvl = LVLW'(NLINES);
            else                   st_d.lvl = lv[LVLW-1:0];
            st_d.v = {st_q.v[3:0], win_i[0].live};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.v[4];

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_therm
            assign therm_o[i] = st_q.v[4] && (st_q.lvl > LVLW'(i));
        end
    endgenerate

    // R8: the lane pipeline advances only on its half-rate enable
    assert_hold_off_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(st_q));

endmodule

// File: rtl/pam4_fir_eq.sv
module pam4_fir_eq
    import pam4_eq_pkg::*;
#(
    parameter int NTAPS = 16,
    parameter int CW    = 10,
    parameter int SHIFT = 6,
    parameter int LVLW  = 4,
    localparam int IDXW   = $clog2(NTAPS),
    localparam int PW     = CW + 2,
    localparam int NLINES = (1 << LVLW) - 1,
    localparam int LAT    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_we,
    input  logic [IDXW-1:0]   coef_idx,
    input  logic [CW-1:0]     coef_val,
    input  logic              sym_vld,
    input  logic [1:0]        sym,
    output logic              out_vld,
    output logic [NLINES-1:0] out_therm
);

    typedef struct packed {
        tap_sym_t [NTAPS:0] hist;   // slot 0 newest, one extra for the even lane
        logic               phase;  // 1: lanes advance at the coming edge
    } top_t;

    top_t st_d, st_q;
    tap_sym_t                 new_slot;
    logic [NTAPS-1:0][CW-1:0] w;
    logic [NTAPS-1:0][PW-1:0] w3;
    logic [1:0]               lane_vld;
    logic [1:0][NLINES-1:0]   lane_therm;

    always_comb begin
        new_slot   = '{live: sym_vld, sym: sym};
        st_d       = st_q;
        st_d.hist  = {st_q.hist[NTAPS-1:0], new_slot};
        st_d.phase = ~st_q.phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pam4_coef_bank #(.NTAPS(NTAPS), .CW(CW)) i_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we_i (coef_we),
        .idx_i(coef_idx),
        .val_i(coef_val),
        .w_o  (w),
        .w3_o (w3)
    );

    // lane 0: even (older symbol, window offset 1); lane 1: odd (offset 0)
    generate
        for (genvar ln = 0; ln < 2; ln++) begin : g_lane
            localparam int OFF = 1 - ln;
            tap_sym_t [NTAPS-1:0] win;
            assign win = st_q.hist[OFF +: NTAPS];
            pam4_eq_lane #(.NTAPS(NTAPS), .CW(CW), .SHIFT(SHIFT), .LVLW(LVLW)) i_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_i   (st_q.phase),
                .win_i  (win),
                .w_i    (w),
                .w3_i   (w3),
                .vld_o  (lane_vld[ln]),
                .therm_o(lane_therm[ln])
            );
        end
    endgenerate

    // 2:1 lane merge: even lane first, then odd
    assign out_vld   = lane_vld[st_q.phase];
    assign out_therm = lane_therm[st_q.phase];

    // R4: a live output always traces back to a live symbol LAT cycles earlier
    assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(sym_vld, LAT));

    // R2: live outputs are contiguous ones from line 0 upward
    assert_therm_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((out_therm & (out_therm + 1'b1)) == '0));

    // R5: dead output slots carry no lines
    assert_dead_slot_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_therm == '0));

endmodule

// File: tb/test_pam4_fir_eq.sv
module test_pam4_fir_eq;

    localparam int CLK_PERIOD = 10;
    localparam int NT   = 16;
    localparam int LAT  = 11;
    localparam int SH   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_idx = '0;
    logic [9:0]  coef_val = '0;
    logic        sym_vld = 1'b0;
    logic [1:0]  sym = '0;
    logic        out_vld;
    logic [14:0] out_therm;

    pam4_fir_eq i_pam4_fir_eq (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
        .coef_val(coef_val), .sym_vld(sym_vld), .sym(sym),
        .out_vld(out_vld), .out_therm(out_therm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string req   = "R7";

    int coef [NT];
    int hv   [NT];
    logic [15:0] expq [$];   // {vld, therm}

    function automatic int level_of(logic [1:0] s);   // R1 mapping
        case (s)
            2'b00:   return -3;
            2'b01:   return -1;
            2'b11:   return 1;
            default: return 3;
        endcase
    endfunction

    // one cycle: check the output, drive a slot, advance the model
    task automatic step(input logic v, input logic [1:0] s);
        logic [15:0] e;
        int acc, lvl;
        e = expq.pop_front();
        n_vec++;
        if (out_vld !== e[15] || out_therm !== e[14:0]) begin
            n_bad++;
            $display("FAIL %s/R4: got vld %0b therm %h, expected vld %0b therm %h",
                     req, out_vld, out_therm, e[15], e[14:0]);
        end
        sym_vld = v;
        sym     = s;
        for (int k = NT-1; k > 0; k--) hv[k] = hv[k-1];
        hv[0] = v ? level_of(s) : 0;       // R5: dead slots weigh nothing
        acc = 0;
        for (int k = 0; k < NT; k++) acc += coef[k] * hv[k];   // R6 tap order
        lvl = (acc >>> SH) + 8;             // R2
        if (lvl < 0) lvl = 0;               // R3
        if (lvl > 15) lvl = 15;
        expq.push_back(v ? {1'b1, 15'((1 << lvl) - 1)} : 16'h0);
        @(negedge clk);
    endtask

    task automatic flush(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00);
    endtask

    task automatic load(input int idx, input int val);
        coef_we  = 1'b1;
        coef_idx = 4'(idx);
        coef_val = 10'(val);
        coef[idx] = val;
        step(1'b0, 2'b00);
        coef_we = 1'b0;
    endtask

    task automatic load_all(input int val);
        flush(18);
        for (int k = 0; k < NT; k++) load(k, val);
    endtask

    initial begin
        for (int k = 0; k < NT; k++) begin coef[k] = 0; hv[k] = 0; end
        for (int i = 0; i < LAT; i++) expq.push_back(16'h0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset weights give level 8; also reset outputs quiet
        req = "R7";
        for (int i = 0; i < 40; i++) step(1'b1, 2'($urandom));

        // R1 / R8: unit weight at tap 0, every code in turn, both lanes
        req = "R1/R8";
        flush(18);
        load(0, 64);
        for (int i = 0; i < 32; i++) step(1'b1, 2'(i));

        // R6: unit weight moved to tap 5
        req = "R6";
        flush(18);
        load(0, 0);
        load(5, 64);
        for (int i = 0; i < 40; i++) step(1'b1, 2'($urandom));

        // R5 / R2: random weights, random gaps
        req = "R5/R2";
        flush(18);
        for (int k = 0; k < NT; k++) load(k, int'($urandom_range(0, 300)) - 150);
        for (int i = 0; i < 200; i++) step(($urandom % 3) != 0, 2'($urandom));

        // R3: clamp at both ends
        req = "R3";
        load_all(511);
        for (int i = 0; i < 30; i++) step(1'b1, 2'b10);
        for (int i = 0; i < 30; i++) step(1'b1, 2'b00);

        // R9: most negative weight against -3 and +3
        req = "R9";
        load_all(-512);
        for (int i = 0; i < 30; i++) step(1'b1, 2'b00);
        for (int i = 0; i < 30; i++) step(1'b1, 2'b10);
        flush(18);
        for (int k = 0; k < NT; k++) load(k, 0);
        load(0, -512);
        load(3, 37);
        for (int i = 0; i < 60; i++) step(1'b1, 2'($urandom));

        flush(LAT + 2);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule